// File: doc/BRIEF.md
# Interframe Gap Timer

This block times the 96-bit-time quiet interval a station must observe before it may start a transmit. It counts bit-time ticks supplied by the surrounding MAC. Because the count moves only on those tick pulses, the block works at any media clock rate. When the interval has run out it raises `gap_done`. That output stays high until the station starts a new transmit or, in half duplex, until the medium becomes busy again.

The trigger depends on the duplex setting. In half duplex the interval is measured from the moment carrier sense goes low, and it has two phases. During the first 64 bit times, any carrier throws the count away: the timer waits for the medium to go quiet and then starts again from zero. During the last 32 bit times, carrier is disregarded and the count runs to 96. In full duplex, the interval starts at the end of the station's own transmit, which is marked by a one-cycle pulse, and carrier sense plays no part. After reset the block times one full gap straight away.

Top module: `ifg_timer`

## Requirements
- R1: During reset `gap_done` is 0. After reset is released, the timer starts counting from zero at once, and with carrier low `gap_done` rises after 96 counted ticks.
- R2: The count advances only in cycles where `bit_tick` is 1. `gap_done` goes high in the cycle after the clock edge that samples the 96th counted tick.
- R3: In half duplex (`full_duplex`=0), with the timer waiting, a cycle with `carrier_sense` low starts a fresh count from zero at the next edge. Ticks are counted from the edge after that one.
- R4: In half duplex, carrier high while fewer than 64 ticks have been counted discards the count. The timer waits until carrier is low again and then needs a full 96 ticks.
- R5: In half duplex, carrier high once 64 or more ticks have been counted is ignored, and `gap_done` rises at the 96th tick.
- R6: In half duplex, carrier high while `gap_done` is 1 clears `gap_done` at the next edge.
- R7: In full duplex (`full_duplex`=1), a `tx_end` pulse starts a count from zero, and also restarts a count already in progress or a completed one. `gap_done` rises after 96 ticks.
- R8: In full duplex, `carrier_sense` has no effect on the count or on `gap_done`.
- R9: A `tx_start` pulse clears `gap_done` at the next edge. The output stays low until a new gap has been timed: in half duplex this begins with carrier low, in full duplex with `tx_end`.
- R10: When `tx_start` and `tx_end` are both 1 in the same cycle, `tx_start` wins and the timer waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| carrier_sense | input | 1 | Medium busy indication |
| tx_start | input | 1 | Pulse: the station begins a transmit |
| tx_end | input | 1 | Pulse: the station's transmit has ended |
| full_duplex | input | 1 | 1 selects full duplex, 0 selects half duplex |
| gap_done | output | 1 | Registered: the interframe gap has elapsed |

## Verification
The hardest case to reach from the ports is the half-duplex phase boundary. Carrier must arrive exactly after 63 counted ticks, which must restart the count, or exactly after 64, which must be ignored. Random carrier rarely lands on either count. Directed sequences therefore count ticks to exactly 63 and to exactly 64 before raising carrier. Random traffic with long quiet runs and sparse ticks then compares every cycle against a bench model. That model exercises mode changes and the case where `tx_start` and `tx_end` collide.

// File: rtl/ifg_pkg.sv
package ifg_pkg;
  typedef enum logic [1:0] {
    GAP_WAIT = 2'd0,
    GAP_RUN  = 2'd1,
    GAP_DONE = 2'd2
  } gap_state_t;
endpackage

// File: rtl/ifg_event_sel.sv
module ifg_event_sel (
  input  logic full_duplex,
  input  logic carrier_sense,
  input  logic tx_start,
  input  logic tx_end,
  output logic abort,
  output logic fd_launch,
  output logic hd_carrier,
  output logic hd_mode
);
  // Mode-qualified events: carrier only matters in half duplex (R8),
  // the end-of-transmit trigger only in full duplex (R7).
  always_comb begin
    hd_mode    = ~full_duplex;
    abort      = tx_start;
    fd_launch  = full_duplex & tx_end & ~tx_start;
    hd_carrier = ~full_duplex & carrier_sense;
  end
endmodule

// File: rtl/ifg_counter.sv
module ifg_counter #(
  parameter int GAP_BITS   = 96,
  parameter int EARLY_BITS = 64,
  localparam int CNT_W     = $clog2(GAP_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             bit_tick,
  output logic [CNT_W-1:0] count,
  output logic             early,
  output logic             terminal
);
  localparam logic [CNT_W-1:0] EARLY_LIM = CNT_W'(EARLY_BITS);
  localparam logic [CNT_W-1:0] LAST_VAL  = CNT_W'(GAP_BITS - 1);

  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else if (bit_tick) count <= count + 1'b1;
  end

  always_comb begin
    early    = (count < EARLY_LIM);
    terminal = (count == LAST_VAL);
  end

  // R2: without a tick and without a clear, the count holds
  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
    (!clear && !bit_tick) |=> $stable(count));
  // R2: the count never passes the last bit time of the gap
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    count <= LAST_VAL);
endmodule

// File: rtl/ifg_fsm.sv
module ifg_fsm
  import ifg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_tick,
  input  logic       abort,
  input  logic       fd_launch,
  input  logic       hd_carrier,
  input  logic       hd_mode,
  input  logic       early,
  input  logic       terminal,
  output gap_state_t state,
  output logic       cnt_clear,
  output logic       gap_done
);
  gap_state_t nxt;

  always_comb begin
    nxt = state;
    if (abort) nxt = GAP_WAIT;
    else if (fd_launch) nxt = GAP_RUN;
    else begin
      unique case (state)
        GAP_WAIT: if (hd_mode && !hd_carrier) nxt = GAP_RUN;
        GAP_RUN: begin
          if (hd_carrier && early) nxt = GAP_WAIT;
          else if (bit_tick && terminal) nxt = GAP_DONE;
        end
        GAP_DONE: if (hd_carrier) nxt = GAP_WAIT;
        default: nxt = GAP_WAIT;
      endcase
    end
  end

  // Count only while staying in the running state; otherwise hold at zero.
  assign cnt_clear = (nxt != GAP_RUN) || (state != GAP_RUN) || fd_launch;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= GAP_RUN;
      gap_done <= 1'b0;
    end else begin
      state    <= nxt;
      gap_done <= (nxt == GAP_DONE);
    end
  end

  // R2: completion only follows a sampled tick
  p_done_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(gap_done) |-> $past(bit_tick));
  // R4: early carrier drops back to waiting
  p_early_restart_r4: assert property (@(posedge clk) disable iff (rst)
    (state == GAP_RUN && hd_carrier && early && !abort) |=> (state == GAP_WAIT && !gap_done));
  // R5: late in the gap nothing but tx_start stops the count
  p_late_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (state == GAP_RUN && !early && !abort) |=> (state != GAP_WAIT));
  // R6: carrier cancels a completed gap in half duplex
  p_carrier_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (state == GAP_DONE && hd_carrier && !abort) |=> !gap_done);
  // R8: in full duplex a completed gap persists regardless of carrier
  p_fd_persist_r8: assert property (@(posedge clk) disable iff (rst)
    (state == GAP_DONE && !hd_mode && !abort && !fd_launch) |=> gap_done);
  // R9: a transmit start always clears the output
  p_start_clears_r9: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!gap_done && state == GAP_WAIT));
endmodule

// File: rtl/ifg_timer.sv
module ifg_timer #(
  parameter int GAP_BITS   = 96,
  parameter int EARLY_BITS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic carrier_sense,
  input  logic tx_start,
  input  logic tx_end,
  input  logic full_duplex,
  output logic gap_done
);
  import ifg_pkg::*;
  localparam int CNT_W = $clog2(GAP_BITS);

  logic abort, fd_launch, hd_carrier, hd_mode;
  logic cnt_clear, early, terminal;
  logic [CNT_W-1:0] count;
  gap_state_t state;

  ifg_event_sel u_sel (
    .full_duplex   (full_duplex),
    .carrier_sense (carrier_sense),
    .tx_start      (tx_start),
    .tx_end        (tx_end),
    .abort         (abort),
    .fd_launch     (fd_launch),
    .hd_carrier    (hd_carrier),
    .hd_mode       (hd_mode)
  );

  ifg_counter #(.GAP_BITS(GAP_BITS), .EARLY_BITS(EARLY_BITS)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clear    (cnt_clear),
    .bit_tick (bit_tick),
    .count    (count),
    .early    (early),
    .terminal (terminal)
  );

  ifg_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .bit_tick   (bit_tick),
    .abort      (abort),
    .fd_launch  (fd_launch),
    .hd_carrier (hd_carrier),
    .hd_mode    (hd_mode),
    .early      (early),
    .terminal   (terminal),
    .state      (state),
    .cnt_clear  (cnt_clear),
    .gap_done   (gap_done)
  );

  // R10: simultaneous start and end leaves the timer waiting
  p_start_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (tx_start && tx_end) |=> (state == GAP_WAIT && count == '0));
endmodule

// File: tb/ifg_timer_test.sv
module ifg_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 96;
  localparam int EARLY = 64;

  logic clk = 1'b0;
  logic rst, bit_tick, carrier_sense, tx_start, tx_end, full_duplex;
  logic gap_done;
  int checks = 0;
  int failures = 0;
  int m_state;  // 0 wait, 1 run, 2 done
  int m_cnt;

  ifg_timer uut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .carrier_sense(carrier_sense),
    .tx_start(tx_start), .tx_end(tx_end), .full_duplex(full_duplex),
    .gap_done(gap_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic void model_step(input logic r, input logic t, input logic cs,
                                     input logic ts, input logic te, input logic fd);
    if (r) begin m_state = 1; m_cnt = 0; return; end
    if (ts) begin m_state = 0; m_cnt = 0; end
    else if (fd && te) begin m_state = 1; m_cnt = 0; end
    else if (m_state == 0) begin
      if (!fd && !cs) begin m_state = 1; m_cnt = 0; end
    end else if (m_state == 1) begin
      if (!fd && cs && m_cnt < EARLY) begin m_state = 0; m_cnt = 0; end
      else if (t) begin
        if (m_cnt == GAP - 1) begin m_state = 2; m_cnt = 0; end
        else m_cnt++;
      end
    end else begin
      if (!fd && cs) m_state = 0;
    end
  endfunction

  task automatic check(input logic exp, input string tag);
    checks++;
    if (gap_done !== exp) begin
      failures++;
      $display("FAIL %s gap_done actual=%0b expected=%0b t=%0t", tag, gap_done, exp, $time);
    end
  endtask

  // drive one cycle, advance the model, compare after the edge
  task automatic step(input logic t, input logic cs, input logic ts, input logic te,
                      input string tag);
    bit_tick = t; carrier_sense = cs; tx_start = ts; tx_end = te;
    model_step(rst, t, cs, ts, te, full_duplex);
    @(negedge clk);
    check(m_state == 2, tag);
  endtask

  task automatic ticks(input int n, input logic cs, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, cs, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; bit_tick = 0; carrier_sense = 0; tx_start = 0; tx_end = 0; full_duplex = 0;
    m_state = 1; m_cnt = 0;
    @(negedge clk);
    step(1'b1, 1'b0, 1'b0, 1'b0, "R1");
    check(1'b0, "R1");
    rst = 1'b0;
    // R1: timer runs from reset: 95 ticks low, 96th high
    ticks(95, 1'b0, "R1");
    check(1'b0, "R1");
    ticks(1, 1'b0, "R1");
    check(1'b1, "R1");
    // R6: carrier while done clears it
    step(1'b0, 1'b1, 1'b0, 1'b0, "R6");
    check(1'b0, "R6");
    // R3: carrier drop starts count; idle cycles without tick do nothing (R2)
    step(1'b0, 1'b0, 1'b0, 1'b0, "R3");
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 1'b0, 1'b0, "R2");
    // R4: carrier after 63 ticks discards the count
    ticks(63, 1'b0, "R4");
    step(1'b1, 1'b1, 1'b0, 1'b0, "R4");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R4");
    ticks(95, 1'b0, "R4");
    check(1'b0, "R4");
    ticks(1, 1'b0, "R4");
    check(1'b1, "R4");
    // R5: carrier after 64 ticks is ignored
    step(1'b0, 1'b1, 1'b0, 1'b0, "R5");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R5");
    ticks(64, 1'b0, "R5");
    ticks(31, 1'b1, "R5");
    check(1'b0, "R5");
    ticks(1, 1'b1, "R5");
    check(1'b1, "R5");
    step(1'b0, 1'b1, 1'b0, 1'b0, "R6");
    check(1'b0, "R6");
    // R7/R8: full duplex, carrier held high throughout
    full_duplex = 1'b1;
    step(1'b0, 1'b1, 1'b0, 1'b1, "R7");
    ticks(50, 1'b1, "R8");
    step(1'b0, 1'b1, 1'b0, 1'b1, "R7");
    ticks(95, 1'b1, "R7");
    check(1'b0, "R7");
    ticks(1, 1'b1, "R8");
    check(1'b1, "R8");
    for (int i = 0; i < 20; i++) step(1'b1, i[0], 1'b0, 1'b0, "R8");
    check(1'b1, "R8");
    // R9: transmit start clears and stays low without a tx_end
    step(1'b0, 1'b0, 1'b1, 1'b0, "R9");
    check(1'b0, "R9");
    ticks(120, 1'b0, "R9");
    check(1'b0, "R9");
    // R10: start and end together: still waiting
    step(1'b0, 1'b0, 1'b1, 1'b1, "R10");
    ticks(120, 1'b0, "R10");
    check(1'b0, "R10");
    // random mixed traffic
    void'($urandom(32'h1F6A));
    begin
      logic cs_r = 1'b0;
      for (int i = 0; i < 40000; i++) begin
        logic t, ts, te;
        if ($urandom_range(0, 999) == 0) full_duplex = ~full_duplex;
        if ($urandom_range(0, 99) < 3) cs_r = ~cs_r;
        t  = ($urandom_range(0, 3) == 0);
        ts = ($urandom_range(0, 499) == 0);
        te = ($urandom_range(0, 299) == 0);
        step(t, cs_r, ts, te, full_duplex ? "R7" : "R3");
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule